// File: doc/BRIEF.md
# Streaming Radix-2 Butterfly Stage with Feedback Delay

This block is one stage of a streaming pipelined FFT built in decimation-in-frequency form. It accepts one complex sample per valid clock and pairs each sample with the one that arrived half a transform earlier. The pairing uses a single feedback delay line that is `DEPTH` complex words deep, where `DEPTH` is half the transform size seen by this stage. Twiddle rotation is not part of this stage. Rotation by -j is not part of it either. Stages for a full transform are chained, each with half the depth of the one before it.

The stage alternates between two phases, and each phase lasts `DEPTH` valid samples. In the fill phase, the incoming sample is written into the delay line. The word leaving the line is sent out: it is the difference that the previous butterfly phase left there. In the butterfly phase, the stored sample and the incoming sample are added and the sum is sent out at once. Their difference (stored minus incoming) is written back into the same slot, and it emerges during the next fill phase. The same storage therefore holds first-half samples and pending differences in turn, so none of it sits idle.

Every output word carries one guard bit above the input width. Arithmetic is two's complement. The real and imaginary parts run through two identical lanes, and each lane has its own adder, subtractor and delay line.

Top module: `sdf_r2_stage`

## Requirements
- R1: A synchronous active-high reset clears the output valid and both output words to zero, and returns the stage to the fill phase with its sample counter at zero.
- R2: The output valid stays low for the first `DEPTH` valid inputs after reset. It goes high for every valid input after that.
- R3: The phase changes after every `DEPTH` valid inputs. Cycles with the input valid low do not advance the sample counter or the phase.
- R4: In the butterfly phase, the output is x(n) + x(n+DEPTH), where x(n) is the sample stored in the same slot during the preceding fill phase. The output is sign-extended to DW+1 bits.
- R5: In a fill phase after the first one, the output is x(n) - x(n+DEPTH) from the preceding butterfly phase. These differences appear in the same slot order in which the sums were produced.
- R6: The real and imaginary lanes are computed independently. A value on one lane never appears in the other.
- R7: Each output is registered and appears on the clock edge that accepts its input. When the input valid is low, the output valid drops on the next edge and both output words hold their values.
- R8: Full-scale inputs (the most positive and most negative DW-bit values, in any combination) produce exact sums and differences with no wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_re | input | DW | Real part of input, two's complement |
| in_im | input | DW | Imaginary part of input, two's complement |
| out_valid | output | 1 | Output sample strobe |
| out_re | output | DW+1 | Real part of result |
| out_im | output | DW+1 | Imaginary part of result |

## Verification
The bench builds the stage with DW = 8 and DEPTH = 4, which gives an eight-point butterfly. At this size, several complete frames, idle gaps inside a frame, and a reset partway through a frame all fit in a short run. The 8-bit width lets the bench drive the exact limits of +127 and -128. This exercises the sum 254 and the difference -255 in the 9-bit output, which R8 requires to come out without wrapping. A reference model in the bench applies the phase rules of R3 to R5 and queues one expected word pair for every valid output. The output is compared against that queue on every valid output.

// File: rtl/sdf_r2_pkg.sv
package sdf_r2_pkg;
  typedef enum logic {
    PH_FILL = 1'b0,
    PH_BFLY = 1'b1
  } phase_t;

  localparam int LANES = 2;
endpackage

// File: rtl/sdf_r2_ctrl.sv
module sdf_r2_ctrl
  import sdf_r2_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output phase_t        phase,
  output logic [AW-1:0] slot,
  output logic          primed
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot   <= '0;
      phase  <= PH_FILL;
      primed <= 1'b0;
    end else if (in_valid) begin
      if (slot == LAST) begin
        slot   <= '0;
        phase  <= (phase == PH_FILL) ? PH_BFLY : PH_FILL;
        primed <= 1'b1;
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdf_r2_delay.sv
module sdf_r2_delay #(
  parameter int W     = 9,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/sdf_r2_lane.sv
module sdf_r2_lane
  import sdf_r2_pkg::*;
#(
  parameter int DW    = 12,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  phase_t        phase,
  input  logic [AW-1:0] slot,
  input  logic [DW-1:0] x,
  output logic [DW:0]   y
);
  logic [DW:0] x_ext;
  logic [DW:0] held;
  logic [DW:0] sum;
  logic [DW:0] diff;
  logic [DW:0] wr_word;
  logic [DW:0] y_next;

  assign x_ext   = {x[DW-1], x};
  assign sum     = held + x_ext;
  assign diff    = held - x_ext;
  assign wr_word = (phase == PH_BFLY) ? diff : x_ext;
  assign y_next  = (phase == PH_BFLY) ? sum : held;

  sdf_r2_delay #(.W(DW + 1), .DEPTH(DEPTH)) u_delay (
    .clk  (clk),
    .we   (en),
    .addr (slot),
    .wdata(wr_word),
    .rdata(held)
  );

  always_ff @(posedge clk) begin
    if (rst)     y <= '0;
    else if (en) y <= y_next;
  end
endmodule

// File: rtl/sdf_r2_stage.sv
module sdf_r2_stage
  import sdf_r2_pkg::*;
#(
  parameter int DW    = 12,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_re,
  input  logic [DW-1:0] in_im,
  output logic          out_valid,
  output logic [DW:0]   out_re,
  output logic [DW:0]   out_im
);
  phase_t        phase;
  logic [AW-1:0] slot;
  logic          primed;
  logic [DW-1:0] lane_in  [LANES];
  logic [DW:0]   lane_out [LANES];

  sdf_r2_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .in_valid(in_valid),
    .phase   (phase),
    .slot    (slot),
    .primed  (primed)
  );

  assign lane_in[0] = in_re;
  assign lane_in[1] = in_im;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sdf_r2_lane #(.DW(DW), .DEPTH(DEPTH)) u_lane (
      .clk  (clk),
      .rst  (rst),
      .en   (in_valid),
      .phase(phase),
      .slot (slot),
      .x    (lane_in[g]),
      .y    (lane_out[g])
    );
  end

  assign out_re = lane_out[0];
  assign out_im = lane_out[1];

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid & primed;
  end
endmodule

// File: rtl/sdf_r2_stage_chk.sv
module sdf_r2_stage_chk #(
  parameter int OW = 13,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          out_valid,
  input logic [OW-1:0] out_re,
  input logic [OW-1:0] out_im,
  input logic          phase_bit,
  input logic [AW-1:0] slot,
  input logic          primed
);
  AST_RESET_CLEARS_OUTPUT: assert property (@(posedge clk) $past(rst) |-> (!out_valid && out_re == '0 && out_im == '0)); // R1
  AST_VALID_NEEDS_INPUT: assert property (@(posedge clk) disable iff (rst) out_valid |-> $past(in_valid)); // R7
  AST_IDLE_HOLDS_OUTPUT: assert property (@(posedge clk) disable iff (rst) !in_valid |=> (!out_valid && $stable(out_re) && $stable(out_im))); // R7
  AST_PHASE_ONLY_ON_VALID: assert property (@(posedge clk) disable iff (rst) !in_valid |=> ($stable(phase_bit) && $stable(slot))); // R3
  AST_PRIMED_STICKY: assert property (@(posedge clk) disable iff (rst) primed |=> primed); // R2
  AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (rst) (!primed && !$past(primed)) |-> !out_valid); // R2
endmodule

bind sdf_r2_stage sdf_r2_stage_chk #(.OW(DW + 1), .AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .out_valid(out_valid),
  .out_re   (out_re),
  .out_im   (out_im),
  .phase_bit(phase),
  .slot     (slot),
  .primed   (primed)
);

// File: tb/test_sdf_r2_stage.sv
`timescale 1ns / 1ps
module test_sdf_r2_stage;
  localparam int DW    = 8;
  localparam int DEPTH = 4;

  typedef struct {
    int    re;
    int    im;
    string req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_re = '0;
  logic [DW-1:0] in_im = '0;
  logic          out_valid;
  logic [DW:0]   out_re;
  logic [DW:0]   out_im;

  int   n_chk  = 0;
  int   n_fail = 0;
  exp_t q[$];

  int   k = 0;
  bit   m_primed = 1'b0;
  int   xb_re [DEPTH];
  int   xb_im [DEPTH];
  int   db_re [DEPTH];
  int   db_im [DEPTH];

  always #10 clk = ~clk;

  sdf_r2_stage #(.DW(DW), .DEPTH(DEPTH)) i_sdf_r2_stage (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_re    (in_re),
    .in_im    (in_im),
    .out_valid(out_valid),
    .out_re   (out_re),
    .out_im   (out_im)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    k = 0;
    m_primed = 1'b0;
  endtask

  task automatic drive(input int re, input int im);
    int p;
    exp_t e;
    p = k % (2 * DEPTH);
    if (p < DEPTH) begin
      if (m_primed) begin
        e.re = db_re[p]; e.im = db_im[p]; e.req = "R5";
        q.push_back(e);
      end
      xb_re[p] = re; xb_im[p] = im;
    end else begin
      e.re = xb_re[p-DEPTH] + re; e.im = xb_im[p-DEPTH] + im; e.req = "R4";
      q.push_back(e);
      db_re[p-DEPTH] = xb_re[p-DEPTH] - re;
      db_im[p-DEPTH] = xb_im[p-DEPTH] - im;
    end
    k++;
    if (k >= DEPTH) m_primed = 1'b1;
    in_valid = 1'b1;
    in_re = DW'(re);
    in_im = DW'(im);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    logic [DW:0] last_re;
    logic [DW:0] last_im;
    in_valid = 1'b0;
    @(negedge clk);
    last_re = out_re;
    last_im = out_im;
    for (int i = 1; i < n; i++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R7", int'(out_valid), 0);
      check(out_re == last_re && out_im == last_im, "R7",
            int'($signed(out_re)), int'($signed(last_re)));
    end
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
    @(negedge clk);
    check(out_valid == 1'b0, "R1", int'(out_valid), 0);
    check(out_re == '0 && out_im == '0, "R1", int'($signed(out_re)), 0);
  endtask

  // monitor: one comparison per valid output word pair
  always @(negedge clk) begin
    if (out_valid) begin
      if (q.size() == 0) begin
        check(1'b0, "R2", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(int'($signed(out_re)) == e.re, e.req, int'($signed(out_re)), e.re);
        check(int'($signed(out_im)) == e.im, {e.req, "/R6"}, int'($signed(out_im)), e.im);
      end
    end
  end

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R2: first DEPTH inputs give no output; R3/R4/R5: back-to-back ramps
    for (int i = 0; i < 3 * 2 * DEPTH; i++) drive(i + 1, -3 * i);
    idle(3);

    // R3: gaps inside frames must not advance the phase
    for (int i = 0; i < 2 * DEPTH; i++) begin
      drive(10 * i - 40, 7 - i);
      idle(2 + (i % 3));
    end

    // R8: full-scale extremes, R6: opposite pattern on imaginary lane
    for (int i = 0; i < DEPTH; i++) drive(127, -128);
    for (int i = 0; i < DEPTH; i++) drive(127, 127);
    for (int i = 0; i < DEPTH; i++) drive(-128, 127);
    for (int i = 0; i < DEPTH; i++) drive(127, -128);
    for (int i = 0; i < DEPTH; i++) drive(-128, -128);
    for (int i = 0; i < DEPTH; i++) drive(-128, -128);
    idle(3);

    // R1: reset in mid-frame, then restart from the fill phase
    for (int i = 0; i < 3; i++) drive(5 * i, -2 * i);
    idle(2);
    do_reset();
    for (int i = 0; i < 2 * DEPTH; i++) drive(i * i - 9, 3 - 2 * i);
    // flush pending differences (R5)
    for (int i = 0; i < DEPTH; i++) drive(0, 0);
    idle(3);

    check(q.size() == 0, "R5", q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule